// File: doc/BRIEF.md
# Shared-Clock Timing Arbiter for a Two-Drive IDE Channel

An IDE channel carrying two drives has one base clock, either 50 MHz or 66 MHz, and one set of timing bytes. Those bytes are held in a small configuration space. Software asks for a transfer setting on one drive by giving the drive's unit number, its transfer class (PIO, multiword DMA or Ultra DMA) and a mode number. The block looks up the 16-bit timing word for that mode and the clock the mode prefers. It stores both in a per-drive record, together with a class priority.

The two records then decide which clock the channel runs. When the chosen clock differs from the current one, the block rewrites the control byte's clock-select bit. It then reloads the clock-dependent timing bytes of every drive that has Ultra DMA active. After that it writes the new timing for the requesting drive. All of these updates leave the block as single-byte writes on a valid/ready port, one at a time, in a fixed order.

A paired-setting mode, chosen by a static input, serves older silicon that needs both drives programmed together. In this mode the Ultra DMA enable bits of both drives change as a pair, and every Ultra DMA timing byte is written to both unit slots.

Top module: `dual_clk_ide_arb`

## Requirements
- R1: During and after reset, `busy` and `wr_valid` are low and `req_ready` is high. `clk_sel50` equals bit (1+CHAN) of `ctl_init`. The internal copy of the control byte equals `ctl_init`. Both drive records hold priority 0, clock wish "either", and zero timings.
- R2: A PIO request (class code 0) for mode m uses timing 0xAA88, 0xA382, 0xA181, 0x3332 or 0x3121 for m = 0..4. Modes 0..3 want 66 MHz and mode 4 accepts either clock. The request ends with one write of the timing to address 0x54+4·CHAN. That byte is bits 15:8 of the timing at 66 MHz and bits 7:0 at 50 MHz.
- R3: An Ultra DMA request (class code 2) for mode m = 0..6 uses timing 0x4433, 0x4231, 0x3121, 0x2121, 0x1111, 0x2211 or 0x1111. Modes 5 and 6 additionally OR in 0x8080. The clock wishes are either, 50, either, 66, 66, 50 and 66. In unpaired mode the request ends with one timing write to 0x56+4·CHAN+unit.
- R4: An Ultra DMA or multiword DMA request (class code 1) first writes the control byte at 0x50, read-modify-write from its internal copy. In unpaired mode, Ultra DMA clears bit (3+2·CHAN+unit) and multiword DMA sets it. Multiword DMA modes 0..2 wish either, 66 and either, and write no timing byte.
- R5: The class priorities are PIO 1, multiword DMA 2 and Ultra DMA 3. The clock wish of the drive with the strictly higher priority is taken first; on a tie, unit 1's wish is taken. If that wish is "either", the other drive's wish is used. If the result is "either" or equals the current clock, no clock write occurs.
- R6: A clock change writes 0x50 with bit (1+CHAN) set for 50 MHz and cleared for 66 MHz. All other bits keep their current values. `clk_sel50` follows the new clock.
- R7: After a clock write, the other drive is reprogrammed first, then the requesting drive. Each of them is reprogrammed only if its Ultra DMA timing is non-zero. Reprogramming means its Ultra DMA timing write followed by its PIO timing write at address 0x54+4·CHAN, both for the new clock. The per-request order is: enable-bit write, clock write, the reprogram writes, the final timing write.
- R8: With `pair_mode` high, Ultra DMA ANDs the control byte with the inverse of 0x18<<(2·CHAN) and multiword DMA ORs that mask in. Every Ultra DMA timing write goes to 0x56+4·CHAN and then, with the same byte, to 0x57+4·CHAN.
- R9: `wr_addr` and `wr_data` hold while `wr_valid` is high and `wr_ready` is low. Only one write is outstanding at a time. `busy` rises in the cycle after a request is accepted and stays high until the last write has completed. `req_ready` is the inverse of `busy`.
- R10: Mode numbers above the class maximum are treated as the maximum: PIO 4, multiword DMA 2, Ultra DMA 6. A request with class code 3 is ignored: it produces no write, leaves `busy` low and changes no drive record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctl_init | input | 8 | Stored control byte loaded at reset |
| pair_mode | input | 1 | Paired-setting mode; change only while idle |
| req_valid | input | 1 | Mode request present |
| req_ready | output | 1 | Block is idle and takes a request |
| req_unit | input | 1 | Drive the request is for |
| req_class | input | 2 | 0 PIO, 1 multiword DMA, 2 Ultra DMA, 3 ignored |
| req_mode | input | 3 | Mode number within the class |
| wr_valid | output | 1 | Configuration write pending |
| wr_ready | input | 1 | Write accepted this cycle |
| wr_addr | output | 8 | Configuration byte address |
| wr_data | output | 8 | Configuration byte value |
| busy | output | 1 | A request is being carried out |
| clk_sel50 | output | 1 | Current channel clock, 1 = 50 MHz |

## Verification
Several rules are checked on every cycle. The write port must hold its address and data while stalled, and it must stay quiet when idle. Every control-byte write must keep the bits it does not own. In paired mode the two unit-slot Ultra DMA writes must come back to back with equal data. Ignored requests must not start an operation, and the clock may move only while an operation is running.

Other behaviour needs the bench's reference model and its request sequences: the timing lookup, the clamping of modes, the priority and tie rules behind the clock choice, and which drives get reprogrammed in which order. The bench runs directed cases such as a tie between two Ultra DMA drives and a PIO request that forces a return to 66 MHz, and it also runs long pseudo-random request streams with write-port stalls.

// File: rtl/dcia_pkg.sv
package dcia_pkg;

  typedef enum logic [1:0] {W66 = 2'd0, W50 = 2'd1, WANY = 2'd2} wish_e;
  typedef enum logic [1:0] {XP_PIO = 2'd0, XP_MW = 2'd1, XP_UDMA = 2'd2, XP_NONE = 2'd3} xclass_e;

  localparam int NJOB = 8;
  localparam int JW   = $clog2(NJOB);

  function automatic logic [2:0] clamp_mode(xclass_e c, logic [2:0] m);
    case (c)
      XP_PIO:  return (m > 3'd4) ? 3'd4 : m;
      XP_MW:   return (m > 3'd2) ? 3'd2 : m;
      default: return (m > 3'd6) ? 3'd6 : m;
    endcase
  endfunction

  function automatic logic [1:0] class_prio(xclass_e c);
    case (c)
      XP_PIO:  return 2'd1;
      XP_MW:   return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

  function automatic logic [15:0] class_timing(xclass_e c, logic [2:0] m);
    logic [15:0] t;
    t = 16'h0000;
    case (c)
      XP_PIO:
        case (m)
          3'd0: t = 16'hAA88;
          3'd1: t = 16'hA382;
          3'd2: t = 16'hA181;
          3'd3: t = 16'h3332;
          default: t = 16'h3121;
        endcase
      XP_MW:
        case (m)
          3'd0: t = 16'h8866;
          3'd1: t = 16'h3222;
          default: t = 16'h3121;
        endcase
      default:
        case (m)
          3'd0: t = 16'h4433;
          3'd1: t = 16'h4231;
          3'd2: t = 16'h3121;
          3'd3: t = 16'h2121;
          3'd4: t = 16'h1111;
          3'd5: t = 16'h2211 | 16'h8080;
          default: t = 16'h1111 | 16'h8080;
        endcase
    endcase
    return t;
  endfunction

  function automatic wish_e class_wish(xclass_e c, logic [2:0] m);
    case (c)
      XP_PIO: return (m < 3'd4) ? W66 : WANY;
      XP_MW:  return (m == 3'd1) ? W66 : WANY;
      default:
        case (m)
          3'd1, 3'd5: return W50;
          3'd3, 3'd4, 3'd6: return W66;
          default: return WANY;
        endcase
    endcase
  endfunction

  function automatic logic [7:0] sel_byte(logic [15:0] t, logic is50);
    return is50 ? t[7:0] : t[15:8];
  endfunction

  function automatic logic [JW-1:0] first_job(logic [NJOB-1:0] v);
    logic [JW-1:0] r;
    r = '0;
    for (int i = NJOB - 1; i >= 0; i--) if (v[i]) r = JW'(i);
    return r;
  endfunction

endpackage

// File: rtl/dcia_drive_rec.sv
module dcia_drive_rec
  import dcia_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        upd,
  input  xclass_e     cls,
  input  logic [2:0]  mode,
  output logic [1:0]  pri,
  output wish_e       wish,
  output logic [15:0] pio_t,
  output logic [15:0] udma_t
);

  logic [2:0] m_eff;
  assign m_eff = clamp_mode(cls, mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri    <= 2'd0;
      wish   <= WANY;
      pio_t  <= 16'h0000;
      udma_t <= 16'h0000;
    end else if (upd) begin
      pri  <= class_prio(cls);
      wish <= class_wish(cls, m_eff);
      case (cls)
        XP_PIO:  pio_t  <= class_timing(cls, m_eff);
        XP_MW:   udma_t <= 16'h0000;
        default: udma_t <= class_timing(cls, m_eff);
      endcase
    end
  end

endmodule

// File: rtl/dcia_clk_pick.sv
module dcia_clk_pick
  import dcia_pkg::*;
(
  input  logic [1:0] pri_a,
  input  wish_e      wish_a,
  input  logic [1:0] pri_b,
  input  wish_e      wish_b,
  input  logic       cur50,
  output logic       switch_now,
  output logic       want50
);

  wish_e lead, alt, pick;

  always_comb begin
    if (pri_a > pri_b) begin
      lead = wish_a;
      alt  = wish_b;
    end else begin
      lead = wish_b;
      alt  = wish_a;
    end
    pick       = (lead == WANY) ? alt : lead;
    want50     = (pick == W50);
    switch_now = (pick != WANY) && (want50 != cur50);
  end

endmodule

// File: rtl/dual_clk_ide_arb.sv
module dual_clk_ide_arb
  import dcia_pkg::*;
#(
  parameter int         CHAN     = 0,
  parameter logic [7:0] CTL_ADDR = 8'h50,
  parameter logic [7:0] TIM_BASE = 8'h54
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] ctl_init,
  input  logic       pair_mode,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic       req_unit,
  input  logic [1:0] req_class,
  input  logic [2:0] req_mode,
  output logic       wr_valid,
  input  logic       wr_ready,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  output logic       busy,
  output logic       clk_sel50
);

  localparam int         CLKB      = 1 + CHAN;
  localparam int         UBIT0     = 3 + 2 * CHAN;
  localparam logic [7:0] CLK_MASK  = 8'(1 << CLKB);
  localparam logic [7:0] UB_MASK0  = 8'(1 << UBIT0);
  localparam logic [7:0] UB_MASK1  = 8'(1 << (UBIT0 + 1));
  localparam logic [7:0] PAIR_MASK = UB_MASK0 | UB_MASK1;
  localparam logic [7:0] PIO_ADDR  = 8'(TIM_BASE + 8'(4 * CHAN));
  localparam logic [7:0] UDMA_ADDR = 8'(TIM_BASE + 8'd2 + 8'(4 * CHAN));

  localparam logic [JW-1:0] J_UBIT   = JW'(0);
  localparam logic [JW-1:0] J_CLK    = JW'(1);
  localparam logic [JW-1:0] J_PAIR_U = JW'(2);
  localparam logic [JW-1:0] J_PAIR_P = JW'(3);
  localparam logic [JW-1:0] J_FIN_P  = JW'(7);

  typedef enum logic [1:0] {ST_IDLE, ST_EVAL, ST_RUN} st_e;

  st_e             state;
  logic [NJOB-1:0] jobs;
  logic            half;
  logic [7:0]      ctl_shadow;
  logic            clk50;
  logic            op_unit;
  xclass_e         op_cls;

  logic [1:0]  d_pri  [2];
  wish_e       d_wish [2];
  logic [15:0] d_pio  [2];
  logic [15:0] d_udma [2];

  // named events for the checker
  logic op_accept, wr_fire, clk_switch, want50;

  assign req_ready = (state == ST_IDLE);
  assign busy      = (state != ST_IDLE);
  assign op_accept = req_valid && req_ready && (req_class != 2'd3);
  assign wr_valid  = (state == ST_RUN);
  assign wr_fire   = wr_valid && wr_ready;
  assign clk_sel50 = clk50;

  for (genvar g = 0; g < 2; g++) begin : g_drv
    dcia_drive_rec u_rec (
      .clk    (clk),
      .rst_n  (rst_n),
      .upd    (op_accept && (req_unit == 1'(g))),
      .cls    (xclass_e'(req_class)),
      .mode   (req_mode),
      .pri    (d_pri[g]),
      .wish   (d_wish[g]),
      .pio_t  (d_pio[g]),
      .udma_t (d_udma[g])
    );
  end

  dcia_clk_pick u_pick (
    .pri_a      (d_pri[0]),
    .wish_a     (d_wish[0]),
    .pri_b      (d_pri[1]),
    .wish_b     (d_wish[1]),
    .cur50      (clk50),
    .switch_now (clk_switch),
    .want50     (want50)
  );

  // current job decode
  logic [JW-1:0] cur_job;
  logic          is_u, tgt, twin, last_write;
  logic [7:0]    ubit_val, clk_val;

  always_comb begin
    cur_job = first_job(jobs);
    is_u    = (cur_job >= J_PAIR_U) && !cur_job[0];
    tgt     = (cur_job == J_PAIR_U || cur_job == J_PAIR_P) ? ~op_unit : op_unit;
    twin    = is_u && pair_mode && !half;
    last_write = ((jobs & ~(NJOB'(1) << cur_job)) == '0) && !twin;

    if (pair_mode)
      ubit_val = (op_cls == XP_UDMA) ? (ctl_shadow & ~PAIR_MASK) : (ctl_shadow | PAIR_MASK);
    else if (op_cls == XP_UDMA)
      ubit_val = ctl_shadow & ~(op_unit ? UB_MASK1 : UB_MASK0);
    else
      ubit_val = ctl_shadow | (op_unit ? UB_MASK1 : UB_MASK0);
    clk_val = clk50 ? (ctl_shadow | CLK_MASK) : (ctl_shadow & ~CLK_MASK);

    if (cur_job == J_UBIT) begin
      wr_addr = CTL_ADDR;
      wr_data = ubit_val;
    end else if (cur_job == J_CLK) begin
      wr_addr = CTL_ADDR;
      wr_data = clk_val;
    end else if (is_u) begin
      wr_addr = pair_mode ? (UDMA_ADDR + 8'(half)) : (UDMA_ADDR + 8'(tgt));
      wr_data = sel_byte(d_udma[tgt], clk50);
    end else begin
      wr_addr = PIO_ADDR;
      wr_data = sel_byte(d_pio[tgt], clk50);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      jobs       <= '0;
      half       <= 1'b0;
      ctl_shadow <= ctl_init;
      clk50      <= ctl_init[CLKB];
      op_unit    <= 1'b0;
      op_cls     <= XP_PIO;
    end else begin
      case (state)
        ST_IDLE: if (op_accept) begin
          op_unit <= req_unit;
          op_cls  <= xclass_e'(req_class);
          state   <= ST_EVAL;
        end
        ST_EVAL: begin
          if (clk_switch) clk50 <= want50;
          jobs <= {op_cls == XP_PIO,
                   op_cls == XP_UDMA,
                   {2{clk_switch && (d_udma[op_unit] != 16'h0)}},
                   {2{clk_switch && (d_udma[~op_unit] != 16'h0)}},
                   clk_switch,
                   op_cls != XP_PIO};
          state <= ST_RUN;
        end
        ST_RUN: if (wr_fire) begin
          if (cur_job == J_UBIT || cur_job == J_CLK) ctl_shadow <= wr_data;
          if (twin) half <= 1'b1;
          else begin
            half          <= 1'b0;
            jobs[cur_job] <= 1'b0;
          end
          if (last_write) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dcia_checker.sv
module dcia_checker #(
  parameter int         CHAN     = 0,
  parameter logic [7:0] CTL_ADDR = 8'h50,
  parameter logic [7:0] TIM_BASE = 8'h54
) (
  input logic       clk,
  input logic       rst_n,
  input logic       pair_mode,
  input logic       req_valid,
  input logic       req_ready,
  input logic [1:0] req_class,
  input logic       wr_valid,
  input logic       wr_ready,
  input logic [7:0] wr_addr,
  input logic [7:0] wr_data,
  input logic       busy,
  input logic       clk_sel50,
  input logic       wr_fire,
  input logic       op_accept,
  input logic [7:0] ctl_shadow
);

  localparam logic [7:0] OWN_BITS = 8'(1 << (1 + CHAN)) | 8'(3 << (3 + 2 * CHAN));
  localparam logic [7:0] PIO_A    = 8'(TIM_BASE + 8'(4 * CHAN));
  localparam logic [7:0] UD_A     = 8'(TIM_BASE + 8'd2 + 8'(4 * CHAN));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  p_quiet_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wr_valid);

  p_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    op_accept |=> busy);

  p_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_class == 2'd3 |=> !busy);

  p_legal_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_addr == CTL_ADDR || wr_addr == PIO_A || wr_addr == UD_A || wr_addr == UD_A + 8'd1));

  p_clk_moves_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(clk_sel50) |-> busy);

  p_ctl_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire && wr_addr == CTL_ADDR |-> (wr_data & ~OWN_BITS) == (ctl_shadow & ~OWN_BITS));

  p_pair_twin_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire && pair_mode && wr_addr == UD_A |=> wr_valid && wr_addr == UD_A + 8'd1 && wr_data == $past(wr_data));

endmodule

bind dual_clk_ide_arb dcia_checker #(.CHAN(CHAN), .CTL_ADDR(CTL_ADDR), .TIM_BASE(TIM_BASE)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pair_mode  (pair_mode),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_class  (req_class),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .busy       (busy),
  .clk_sel50  (clk_sel50),
  .wr_fire    (wr_fire),
  .op_accept  (op_accept),
  .ctl_shadow (ctl_shadow)
);

// File: tb/sim_dual_clk_ide_arb.sv
`timescale 1ns/1ps
module sim_dual_clk_ide_arb;

  localparam int CH = 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] ctl_init = 8'h00;
  logic       pair_mode = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic       req_unit = 1'b0;
  logic [1:0] req_class = 2'd0;
  logic [2:0] req_mode = 3'd0;
  logic       wr_valid;
  logic       wr_ready = 1'b1;
  logic [7:0] wr_addr, wr_data;
  logic       busy, clk_sel50;

  always #2.5 clk = ~clk;

  dual_clk_ide_arb #(.CHAN(CH)) u0 (
    .clk, .rst_n, .ctl_init, .pair_mode, .req_valid, .req_ready, .req_unit,
    .req_class, .req_mode, .wr_valid, .wr_ready, .wr_addr, .wr_data, .busy, .clk_sel50
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit stall_en = 1'b0;
  bit inflight = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  // reference model state
  int mpri [2];
  int mwish [2];          // 0 = 66, 1 = 50, 2 = either
  int mpio [2];
  int mudma [2];
  bit mclk50;
  logic [7:0] mshadow;
  logic [15:0] exp_q [$];
  string tag_q [$];

  int tab_pio [5]   = '{'hAA88, 'hA382, 'hA181, 'h3332, 'h3121};
  int wish_pio [5]  = '{0, 0, 0, 0, 2};
  int tab_ud [7]    = '{'h4433, 'h4231, 'h3121, 'h2121, 'h1111, 'h2211, 'h1111};
  int wish_ud [7]   = '{2, 1, 2, 0, 0, 1, 0};
  int wish_mw [3]   = '{2, 0, 2};

  task automatic check(bit ok, string tag, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] pickb(int t);
    return mclk50 ? 8'(t & 'hFF) : 8'((t >> 8) & 'hFF);
  endfunction

  task automatic push(int a, logic [7:0] d, string tag);
    exp_q.push_back({8'(a), d});
    tag_q.push_back(tag);
  endtask

  task automatic push_ud(int u, string tag);
    if (pair_mode) begin
      push('h56 + 4*CH, pickb(mudma[u]), tag);   // R8 both slots, lower first
      push('h57 + 4*CH, pickb(mudma[u]), tag);
    end else
      push('h56 + 4*CH + u, pickb(mudma[u]), tag);
  endtask

  task automatic model_reset(logic [7:0] init);
    for (int i = 0; i < 2; i++) begin
      mpri[i] = 0; mwish[i] = 2; mpio[i] = 0; mudma[i] = 0;
    end
    mshadow = init;
    mclk50  = init[1+CH];
  endtask

  task automatic model_op(int u, int c, int m);
    int c1, c2, lo, hi;
    logic [7:0] mask;
    if (c == 3) return;                       // R10 ignored class
    if (c == 0 && m > 4) m = 4;               // R10 clamp
    if (c == 1 && m > 2) m = 2;
    if (c == 2 && m > 6) m = 6;
    mpri[u] = c + 1;
    if (c == 0) begin mwish[u] = wish_pio[m]; mpio[u] = tab_pio[m]; end
    else if (c == 1) begin mwish[u] = wish_mw[m]; mudma[u] = 0; end
    else begin
      mwish[u] = wish_ud[m];
      mudma[u] = tab_ud[m] | ((m >= 5) ? 'h8080 : 0);
    end
    if (c != 0) begin
      mask = pair_mode ? (8'h18 << (2*CH)) : 8'(1 << (3 + 2*CH + u));
      if (c == 2) mshadow = mshadow & ~mask; else mshadow = mshadow | mask;
      push('h50, mshadow, pair_mode ? "R8" : "R4");
    end
    if (mpri[0] > mpri[1]) begin c1 = mwish[0]; c2 = mwish[1]; end
    else begin c1 = mwish[1]; c2 = mwish[0]; end
    if (c1 == 2) c1 = c2;                      // R5
    if (c1 != 2 && (c1 == 1) != mclk50) begin
      mclk50 = (c1 == 1);
      mshadow[1+CH] = mclk50;
      push('h50, mshadow, "R6");
      lo = 1 - u; hi = u;
      if (mudma[lo] != 0) begin push_ud(lo, "R7"); push('h54 + 4*CH, pickb(mpio[lo]), "R7"); end
      if (mudma[hi] != 0) begin push_ud(hi, "R7"); push('h54 + 4*CH, pickb(mpio[hi]), "R7"); end
    end
    if (c == 2) push_ud(u, "R3");
    if (c == 0) push('h54 + 4*CH, pickb(mpio[u]), "R2");
  endtask

  // ready pattern, changed away from both edges
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    wr_ready = stall_en ? (lfsr[0] | lfsr[3]) : 1'b1;
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (wr_valid && wr_ready) begin
        if (exp_q.size() == 0)
          check(1'b0, "R9 unexpected write", {wr_addr, wr_data}, 0);
        else begin
          logic [15:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({wr_addr, wr_data} == e, t, {wr_addr, wr_data}, e);
        end
      end
      if (!inflight) check(clk_sel50 == mclk50, "R5 clock state", clk_sel50, mclk50);
    end
  end

  task automatic do_reset(logic [7:0] init);
    rst_n = 1'b0; ctl_init = init;
    repeat (3) @(negedge clk);
    model_reset(init);
    // R1 values held during reset
    check(!busy && !wr_valid && req_ready, "R1 in reset", {busy, wr_valid, req_ready}, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !wr_valid && req_ready, "R1 after reset", {busy, wr_valid, req_ready}, 1);
    check(clk_sel50 == init[1+CH], "R1 clock from stored byte", clk_sel50, init[1+CH]);
  endtask

  task automatic run_op(int u, int c, int m);
    model_op(u, c, m);
    inflight  = 1'b1;
    req_valid = 1'b1; req_unit = 1'(u); req_class = 2'(c); req_mode = 3'(m);
    @(negedge clk);
    req_valid = 1'b0;
    if (c == 3) begin
      repeat (3) begin
        check(!busy && !wr_valid, "R10 ignored class", {busy, wr_valid}, 0);
        @(negedge clk);
      end
    end else begin
      check(busy && !req_ready, "R9 busy after accept", {busy, req_ready}, 2);
      while (busy) @(negedge clk);
    end
    check(exp_q.size() == 0, "R9 writes complete at idle", exp_q.size(), 0);
    inflight = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int r;
    model_reset(8'h00);
    do_reset(8'h00);
    // directed, unpaired
    run_op(0, 0, 4);   // R2 PIO4 either, no clock change
    run_op(1, 2, 5);   // R3 UDMA5 wants 50 -> R6 switch, R7 own rewrite
    run_op(0, 1, 1);   // R4 MW1 wants 66, lower priority: no switch
    run_op(1, 0, 0);   // R5 unit1 drops to PIO: MW unit0 wins -> 66, R7
    run_op(0, 2, 3);   // UDMA3 wants 66
    run_op(1, 2, 1);   // R5 tie of UDMA, unit1 (50) wins, R7 pair first
    run_op(0, 0, 7);   // R10 clamp to PIO4
    run_op(1, 2, 7);   // R10 clamp to UDMA6
    run_op(0, 1, 5);   // R10 clamp to MW2
    run_op(1, 3, 2);   // R10 ignored
    run_op(0, 2, 0);   // UDMA0 either
    // paired phase
    pair_mode = 1'b1;
    run_op(0, 2, 1);   // R8
    run_op(1, 1, 0);   // R8 mask OR
    run_op(1, 2, 6);   // R8 twin writes after switch
    stall_en = 1'b1;
    run_op(0, 2, 5);   // R9 with stalls
    // new reset, 50 MHz stored
    pair_mode = 1'b0;
    stall_en  = 1'b0;
    do_reset(8'h65);
    run_op(0, 0, 0);   // R6 back to 66, other bits kept
    stall_en = 1'b1;
    r = 32'h1234_5678;
    for (int k = 0; k < 240; k++) begin
      r = r ^ (r << 13); r = r ^ (r >>> 17); r = r ^ (r << 5);
      if (k % 60 == 0) pair_mode = ~pair_mode;
      run_op(r & 1, (r >> 1) & 3, (r >> 3) & 7);
    end
    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule